// File: doc/BRIEF.md
# Serial Byte Transmitter with Idle Preamble and Break Generation

This block turns bytes written over a small register port into asynchronous serial frames on a single output line. Each data frame is ten bit times long: a low start bit, eight data bits sent least significant bit first, and a high stop bit. One bit time lasts from one pulse of the one-cycle `baud_tick` strobe to the next. A one-byte holding register sits in front of the shift register, so software can queue the next byte while the current frame is still going out. Consecutive bytes then leave with no gap between them.

Two other kinds of character can be sent. Turning the transmitter on queues one character time of constant high level, so a receiver sees a clean idle period before the first frame. Writing the break control bit to 1 queues one character time of constant low level. Holding that bit at 1 keeps break characters coming. Two status flags, data-register-empty and transmit-complete, tell software when it may write again and when the line has gone quiet. Each flag is cleared only by a read of the status register that sees the flag set, followed by a write to the data register.

Top module: `uart_tx_top`

## Requirements
- R1: After reset the status register (address 1) reads 0xC0: bit 7 is data-register-empty and bit 6 is transmit-complete, and all other bits are 0. The control register (address 0; bit 0 is break, bit 1 is enable) reads 0x00, and `txd` is 1.
- R2: A data frame drives, one bit per baud tick, a 0 start bit, then the eight data bits LSB first, then a 1 stop bit. The line changes only in the cycle after a baud tick.
- R3: When the enable bit goes from 0 to 1, ten bit times of constant 1 are sent before any data frame.
- R4: Writing 1 to the break bit queues a break character. A break character is ten bit times of constant 0, and the number of zeros in a break run is a whole number of characters.
- R5: While the break bit stays at 1 with the transmitter enabled, break characters keep following one another. After the bit is cleared, the break character in progress completes.
- R6: A write to the data register (address 2) is accepted only if a status read that saw data-register-empty set came first with no data write in between. Any other data write is ignored. An accepted write clears data-register-empty. The flag sets again when the byte moves into the shift register at the start of its frame.
- R7: Transmit-complete is cleared only by a status read that sees it set, followed by an accepted data write. It sets again once no frame is in progress and no idle, break or data character is waiting.
- R8: A byte accepted while a frame is being sent starts with its start bit on the baud tick that follows the previous frame's stop bit.
- R9: Clearing the enable bit lets the frame in progress finish. After that the line stays at 1 and no new frame starts, even if a byte is waiting, until the transmitter is enabled again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle strobe marking each bit time boundary |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a status read arms the flag-clearing sequence |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| txd | output | 1 | Serial output line, idle high |

## Verification
The data path is driven with 0xA5 and 0x5A, whose alternating bits expose LSB-first ordering and any off-by-one shift. It is also driven with 0x00 and 0xFF, which tell the start and stop bits apart from the payload, and with 0x01 and 0x80, sent back to back, which check the end positions and the gapless hand-off between frames. The remaining sequences check the control features. A byte is loaded while the transmitter is disabled and then enabled, which measures the idle preamble exactly. Two data writes with no status read between them show that the second write is dropped. A short break pulse and a held break are compared by the length of their zero runs, and a mid-frame disable shows that the current frame finishes while a waiting byte stays held.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;

    // register select values
    localparam logic [ADDR_W-1:0] SEL_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] SEL_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] SEL_DATA = 2'd2;

    // bit positions inside the control and status registers
    localparam int CTRL_BRK_BIT   = 0;
    localparam int CTRL_EN_BIT    = 1;
    localparam int STAT_EMPTY_BIT = 7;
    localparam int STAT_DONE_BIT  = 6;

    typedef struct packed {
        logic en;         // transmitter enabled
        logic brk;        // break control level
        logic empty_arm;  // status read saw empty set
        logic done_arm;   // status read saw complete set
        logic done;       // transmit-complete flag
    } ctl_state_t;

endpackage

// File: rtl/uart_tx_regs.sv
module uart_tx_regs
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              eng_pending,
    input  logic              eng_quiet,
    output logic              tx_en,
    output logic              brk_hold,
    output logic              brk_req,
    output logic              load_req,
    output logic [DATA_W-1:0] load_byte,
    output logic              empty_flag,
    output logic              done_flag
);

    ctl_state_t s_d, s_q;
    logic ctrl_wr, stat_rd, data_wr;

    assign ctrl_wr = bus_wr && (bus_addr == SEL_CTRL);
    assign stat_rd = bus_rd && (bus_addr == SEL_STAT);
    assign data_wr = bus_wr && (bus_addr == SEL_DATA);

    assign empty_flag = ~eng_pending;
    assign done_flag  = s_q.done;
    assign tx_en      = s_q.en;
    assign brk_hold   = s_q.brk;
    assign brk_req    = ctrl_wr && bus_wdata[CTRL_BRK_BIT];
    assign load_req   = data_wr && s_q.empty_arm;
    assign load_byte  = bus_wdata[DATA_W-1:0];

    always_comb begin
        s_d = s_q;
        if (ctrl_wr) begin
            s_d.en  = bus_wdata[CTRL_EN_BIT];
            s_d.brk = bus_wdata[CTRL_BRK_BIT];
        end
        if (stat_rd) begin
            if (empty_flag) s_d.empty_arm = 1'b1;
            if (s_q.done)   s_d.done_arm  = 1'b1;
        end
        if (eng_quiet) s_d.done = 1'b1;
        if (data_wr) begin
            s_d.empty_arm = 1'b0;
            s_d.done_arm  = 1'b0;
            if (load_req && s_q.done_arm) s_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{en: 1'b0, brk: 1'b0, empty_arm: 1'b0, done_arm: 1'b0, done: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            SEL_CTRL: begin
                bus_rdata[CTRL_BRK_BIT] = s_q.brk;
                bus_rdata[CTRL_EN_BIT]  = s_q.en;
            end
            SEL_STAT: begin
                bus_rdata[STAT_EMPTY_BIT] = empty_flag;
                bus_rdata[STAT_DONE_BIT]  = s_q.done;
            end
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              tx_en,
    input  logic              brk_hold,
    input  logic              brk_req,
    input  logic              load_req,
    input  logic [DATA_W-1:0] load_byte,
    output logic              txd,
    output logic              pending,
    output logic              quiet,
    output logic              active
);

    localparam int FRAME_W = DATA_W + 2;
    localparam int CNT_W   = $clog2(FRAME_W);

    typedef struct packed {
        logic               en_prev;
        logic               pre;
        logic               brk;
        logic               pend;
        logic [DATA_W-1:0]  hold;
        logic               active;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] shreg;
    } eng_state_t;

    eng_state_t s_d, s_q;
    logic rise, last_bit;

    assign rise     = tx_en & ~s_q.en_prev;
    assign last_bit = (s_q.cnt == CNT_W'(FRAME_W - 1));

    always_comb begin
        s_d = s_q;
        s_d.en_prev = tx_en;
        if (rise)    s_d.pre = 1'b1;
        if (brk_req) s_d.brk = 1'b1;
        if (!tx_en) begin
            s_d.pre = 1'b0;
            s_d.brk = 1'b0;
        end
        if (load_req) begin
            s_d.pend = 1'b1;
            s_d.hold = load_byte;
        end
        if (baud_tick) begin
            if (s_q.active && !last_bit) begin
                s_d.shreg = {1'b1, s_q.shreg[FRAME_W-1:1]};
                s_d.cnt   = s_q.cnt + CNT_W'(1);
            end else begin
                // frame boundary: pick the next character by priority
                s_d.active = 1'b0;
                s_d.cnt    = '0;
                if (tx_en) begin
                    if (s_q.pre || rise) begin
                        s_d.pre    = 1'b0;
                        s_d.shreg  = '1;
                        s_d.active = 1'b1;
                    end else if (s_q.brk || brk_req || brk_hold) begin
                        s_d.brk    = 1'b0;
                        s_d.shreg  = '0;
                        s_d.active = 1'b1;
                    end else if (s_q.pend) begin
                        s_d.pend   = 1'b0;
                        s_d.shreg  = {1'b1, s_q.hold, 1'b0};
                        s_d.active = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign txd     = s_q.active ? s_q.shreg[0] : 1'b1;
    assign pending = s_q.pend;
    assign quiet   = ~(s_q.active | s_q.pend | s_q.pre | s_q.brk);
    assign active  = s_q.active;

endmodule

// File: rtl/uart_tx_top.sv
module uart_tx_top
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              txd
);

    logic              tx_en, brk_hold, brk_req, load_req;
    logic [DATA_W-1:0] load_byte;
    logic              eng_pending, eng_quiet, eng_active;
    logic              empty_flag, done_flag;

    uart_tx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .eng_pending (eng_pending),
        .eng_quiet   (eng_quiet),
        .tx_en       (tx_en),
        .brk_hold    (brk_hold),
        .brk_req     (brk_req),
        .load_req    (load_req),
        .load_byte   (load_byte),
        .empty_flag  (empty_flag),
        .done_flag   (done_flag)
    );

    uart_tx_engine #(.DATA_W(DATA_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .tx_en     (tx_en),
        .brk_hold  (brk_hold),
        .brk_req   (brk_req),
        .load_req  (load_req),
        .load_byte (load_byte),
        .txd       (txd),
        .pending   (eng_pending),
        .quiet     (eng_quiet),
        .active    (eng_active)
    );

endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       baud_tick,
    input logic       tx_en,
    input logic       eng_active,
    input logic       txd,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic       empty_flag,
    input logic       done_flag
);

    // line only moves after a baud tick
    assert_line_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(txd));

    // no frame may start while disabled
    assert_no_start_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !eng_active) |=> !eng_active);

    // empty flag drops only right after a data write
    assert_empty_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(empty_flag) |-> $past(bus_wr && bus_addr == 2'd2));

    // complete flag drops only right after a data write
    assert_done_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_flag) |-> $past(bus_wr && bus_addr == 2'd2));

endmodule

bind uart_tx_top uart_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .tx_en      (tx_en),
    .eng_active (eng_active),
    .txd        (txd),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .empty_flag (empty_flag),
    .done_flag  (done_flag)
);

// File: tb/sim_uart_tx_top.sv
module sim_uart_tx_top;

    localparam int CLK_PERIOD = 10;
    localparam int BAUD_DIV   = 16;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       txd;

    int checks = 0;
    int errors = 0;
    int div_cnt = 0;
    bit done_flag_tb = 1'b0;

    uart_tx_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .txd       (txd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            div_cnt   <= 0;
            baud_tick <= 1'b0;
        end else begin
            div_cnt   <= (div_cnt == BAUD_DIV-1) ? 0 : div_cnt + 1;
            baud_tick <= (div_cnt == BAUD_DIV-1);
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // waits for the next baud tick edge and samples the new line value
    task automatic next_bit(output logic b);
        while (!baud_tick) @(negedge clk);
        @(negedge clk);
        b = txd;
    endtask

    task automatic sync_tick();
        logic b;
        next_bit(b);
    endtask

    task automatic wait_start(output int ones);
        logic b;
        ones = 0;
        next_bit(b);
        while (b && ones < 300) begin
            ones++;
            next_bit(b);
        end
    endtask

    task automatic recv_rest(output logic [7:0] v, output logic stop);
        logic b;
        for (int i = 0; i < 8; i++) begin
            next_bit(b);
            v[i] = b;
        end
        next_bit(stop);
    endtask

    task automatic count_ones(input int n, output int ones);
        logic b;
        ones = 0;
        for (int i = 0; i < n; i++) begin
            next_bit(b);
            if (b) ones++;
        end
    endtask

    task automatic send_byte(input logic [7:0] d, input string tag);
        logic [7:0] st, v;
        logic stop;
        int ones;
        sync_tick();
        bus_read(2'd1, st);
        bus_write(2'd2, d);
        wait_start(ones);
        recv_rest(v, stop);
        check({tag, " R2 data"}, v, d);
        check({tag, " R2 stop"}, stop, 1'b1);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 txd idle", txd, 1'b1);
        bus_read(2'd0, v);
        check("R1 ctrl reset", v, 8'h00);
        bus_read(2'd1, v);
        check("R1 status reset", v, 8'hC0);
    endtask

    task automatic t_preamble();
        logic [7:0] v;
        logic stop, b;
        int ones;
        bus_write(2'd2, 8'hA5);           // armed by the reset read
        bus_read(2'd1, v);
        check("R6 R7 flags after load", v, 8'h00);
        bus_write(2'd0, 8'h02);
        wait_start(ones);
        check("R3 preamble length", ones, 10);
        recv_rest(v, stop);
        check("R2 frame A5", v, 8'hA5);
        check("R2 stop A5", stop, 1'b1);
        next_bit(b);
        bus_read(2'd1, v);
        check("R7 flags after frame", v, 8'hC0);
    endtask

    task automatic t_ignore();
        logic [7:0] v;
        logic stop;
        int ones;
        sync_tick();
        bus_read(2'd1, v);
        bus_write(2'd2, 8'h3C);
        bus_write(2'd2, 8'hC3);           // no status read before: dropped
        bus_read(2'd1, v);
        check("R6 R7 flags cleared", v, 8'h00);
        wait_start(ones);
        recv_rest(v, stop);
        check("R6 accepted byte", v, 8'h3C);
        count_ones(20, ones);
        check("R6 second write ignored", ones, 20);
    endtask

    task automatic t_back2back();
        logic [7:0] v;
        logic stop, b;
        int ones;
        sync_tick();
        bus_read(2'd1, v);
        bus_write(2'd2, 8'h01);
        wait_start(ones);
        bus_read(2'd1, v);
        check("R6 empty set at frame start", v, 8'h80);
        bus_write(2'd2, 8'h80);
        recv_rest(v, stop);
        check("R2 frame 01", v, 8'h01);
        next_bit(b);
        check("R8 gapless start", b, 1'b0);
        recv_rest(v, stop);
        check("R8 frame 80", v, 8'h80);
        check("R8 stop 80", stop, 1'b1);
    endtask

    task automatic t_break_pulse();
        logic [7:0] v;
        logic b;
        int ones, zeros;
        sync_tick();
        bus_write(2'd0, 8'h03);
        bus_write(2'd0, 8'h02);
        bus_read(2'd0, v);
        check("R4 ctrl readback", v, 8'h02);
        wait_start(ones);
        zeros = 1;
        next_bit(b);
        while (!b && zeros < 300) begin
            zeros++;
            next_bit(b);
        end
        check("R4 single break length", zeros, 10);
    endtask

    task automatic t_break_hold();
        logic b;
        int ones, zeros, highs;
        sync_tick();
        bus_write(2'd0, 8'h03);
        wait_start(ones);
        zeros = 1;
        highs = 0;
        for (int i = 0; i < 24; i++) begin
            next_bit(b);
            if (b) highs++; else zeros++;
        end
        check("R5 held break stays low", highs, 0);
        bus_write(2'd0, 8'h02);
        next_bit(b);
        while (!b && zeros < 300) begin
            zeros++;
            next_bit(b);
        end
        check("R5 R4 held break length", zeros, 30);
    endtask

    task automatic t_disable();
        logic [7:0] v;
        logic stop;
        int ones;
        sync_tick();
        bus_read(2'd1, v);
        bus_write(2'd2, 8'h96);
        wait_start(ones);
        bus_write(2'd0, 8'h00);
        recv_rest(v, stop);
        check("R9 frame finishes", v, 8'h96);
        check("R9 stop after disable", stop, 1'b1);
        count_ones(20, ones);
        check("R9 idle while disabled", ones, 20);
        bus_read(2'd1, v);
        check("R7 complete while idle", v, 8'hC0);
        bus_write(2'd2, 8'h4B);
        count_ones(15, ones);
        check("R9 waiting byte held", ones, 15);
        bus_read(2'd1, v);
        check("R6 R7 byte waiting", v, 8'h00);
        bus_write(2'd0, 8'h02);
        wait_start(ones);
        check("R3 preamble on re-enable", ones, 10);
        recv_rest(v, stop);
        check("R9 held byte sent", v, 8'h4B);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done_flag_tb) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_preamble();
        t_ignore();
        t_back2back();
        send_byte(8'h00, "pattern 00");
        send_byte(8'hFF, "pattern FF");
        send_byte(8'h5A, "pattern 5A");
        t_break_pulse();
        t_break_hold();
        t_disable();
        done_flag_tb = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule